// File: doc/BRIEF.md
# Stereo Output Mode Mixer

This block sits on the per-frame sample path of an audio output stage. Each frame it takes one signed left sample and one signed right sample, strobed by `in_valid`. For each of the two outputs it then picks a source: silence, the left input, the right input or the mean of both. It scales the chosen value by a per-channel attenuation code and registers the result. With this one mechanism the block covers normal stereo, swapped stereo, mono and either channel on both sides.

The block keeps four 16-bit control words, which a plain parallel write port loads. Word 0 holds the left attenuation code in its low byte and word 1 holds the right code. Word 2 is kept but has no effect on the datapath. Word 3 holds the link bit and the two 2-bit source selectors. When the link bit is set, the right channel uses the left code.

Top module: `stereo_mode_mixer`

## Requirements
- R1: After reset the control words are word0 = 0x00FF, word1 = 0x02FF, word2 = 0x0400 and word3 = 0x0690, `out_l`/`out_r` are 0 and `out_valid` is 0. This gives normal stereo at unity gain.
- R2: The left source comes from word3 bits [5:4]: 00 is mute, 01 takes left, 10 takes right and 11 takes the average.
- R3: The right source comes from word3 bits [7:6]: 00 is mute, 01 takes left, 10 takes right and 11 takes the average.
- R4: The average is floor((L+R)/2), computed one bit wider than a sample, so full-scale inputs of either sign never wrap.
- R5: Each output equals trunc(source × code / 255), rounded toward zero. The left code is word0[7:0] and the right code is word1[7:0]. A code of 0xFF passes the source unchanged and a code of 0 gives 0.
- R6: When word3 bit 3 is 1, the right channel uses word0[7:0] and word1 has no effect on either output.
- R7: A muted output is exactly 0 whatever the attenuation code.
- R8: The outputs load only on a clock edge where `in_valid` is 1 and hold otherwise. `out_valid` is `in_valid` delayed by one cycle.
- R9: A write with `wr_en` = 1 updates word `wr_addr` at that edge. A frame strobed at the same edge still uses the previous control words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One frame present on `in_l`/`in_r` |
| in_l | input | DATA_W | Left input sample, signed |
| in_r | input | DATA_W | Right input sample, signed |
| wr_en | input | 1 | Control word write strobe |
| wr_addr | input | 2 | Control word index |
| wr_data | input | 16 | Control word value |
| out_l | output | DATA_W | Left output sample, signed |
| out_r | output | DATA_W | Right output sample, signed |
| out_valid | output | 1 | New output frame this cycle |

## Verification
The assertions take `in_valid`, `in_l` and `in_r` to be at known levels on every clock after reset. The link and source properties also assume that the control words do not change on a frame edge unless the frame is meant to use the old values. The bench drives all inputs on the falling edge and keeps them defined in every cycle. It issues writes either alone or together with a frame, so that the R9 ordering is exercised on purpose.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int REG_W   = 16;
  localparam int NREG    = 4;
  localparam int ADDR_W  = $clog2(NREG);
  localparam int ATT_W   = 8;
  localparam int SEL_W   = 2;
  localparam int NCH     = 2;

  localparam int IDX_ATT_L = 0;
  localparam int IDX_ATT_R = 1;
  localparam int IDX_MODE  = 3;
  localparam int BIT_LINK  = 3;
  localparam int LSB_SEL_L = 4;
  localparam int LSB_SEL_R = 6;

  typedef enum logic [SEL_W-1:0] {
    SRC_MUTE = 2'b00,
    SRC_L    = 2'b01,
    SRC_R    = 2'b10,
    SRC_AVG  = 2'b11
  } src_e;

  function automatic logic [REG_W-1:0] reg_rst_val(input int idx);
    case (idx)
      0:       reg_rst_val = 16'h00FF;
      1:       reg_rst_val = 16'h02FF;
      2:       reg_rst_val = 16'h0400;
      default: reg_rst_val = 16'h0690;
    endcase
  endfunction
endpackage

// File: rtl/smm_regs.sv
module smm_regs
  import smm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [ATT_W-1:0]  code_l,
  output logic [ATT_W-1:0]  code_r,
  output src_e              sel_l,
  output src_e              sel_r
);
  logic [REG_W-1:0] word_q [NREG];
  logic [REG_W-1:0] word_d [NREG];
  logic             link;
  logic             unused_bits;

  always_comb begin
    word_d = word_q;
    if (wr_en) word_d[wr_addr] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) word_q[i] <= reg_rst_val(i);
    end else begin
      for (int i = 0; i < NREG; i++) word_q[i] <= word_d[i];
    end
  end

  assign link   = word_q[IDX_MODE][BIT_LINK];
  assign code_l = word_q[IDX_ATT_L][ATT_W-1:0];
  assign code_r = link ? word_q[IDX_ATT_L][ATT_W-1:0]
                       : word_q[IDX_ATT_R][ATT_W-1:0];
  assign sel_l  = src_e'(word_q[IDX_MODE][LSB_SEL_L +: SEL_W]);
  assign sel_r  = src_e'(word_q[IDX_MODE][LSB_SEL_R +: SEL_W]);

  assign unused_bits = ^{word_q[IDX_ATT_L][REG_W-1:ATT_W],
                         word_q[IDX_ATT_R][REG_W-1:ATT_W],
                         word_q[2],
                         word_q[IDX_MODE][REG_W-1:LSB_SEL_R+SEL_W],
                         word_q[IDX_MODE][BIT_LINK-1:0]};
endmodule

// File: rtl/smm_src_sel.sv
module smm_src_sel
  import smm_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic signed [DATA_W-1:0] smp_l,
  input  logic signed [DATA_W-1:0] smp_r,
  input  src_e                     sel,
  output logic signed [DATA_W-1:0] src
);
  localparam int SUM_W = DATA_W + 1;
  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] half;

  always_comb begin
    sum  = SUM_W'(smp_l) + SUM_W'(smp_r);
    half = sum >>> 1;
    case (sel)
      SRC_L:   src = smp_l;
      SRC_R:   src = smp_r;
      SRC_AVG: src = DATA_W'(half);
      default: src = '0;
    endcase
  end
endmodule

// File: rtl/smm_scale.sv
module smm_scale
  import smm_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic signed [DATA_W-1:0] smp,
  input  logic        [ATT_W-1:0]  code,
  output logic signed [DATA_W-1:0] res
);
  localparam int PROD_W = DATA_W + ATT_W + 1;
  localparam logic signed [PROD_W-1:0] FULL = PROD_W'((1 << ATT_W) - 1);
  logic signed [PROD_W-1:0] prod;

  always_comb begin
    prod = PROD_W'(smp) * $signed({1'b0, code});
    res  = DATA_W'(prod / FULL);
  end
endmodule

// File: rtl/stereo_mode_mixer.sv
module stereo_mode_mixer
  import smm_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_l,
  input  logic signed [DATA_W-1:0] in_r,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [REG_W-1:0]         wr_data,
  output logic signed [DATA_W-1:0] out_l,
  output logic signed [DATA_W-1:0] out_r,
  output logic                     out_valid
);
  logic [ATT_W-1:0] code_l, code_r;
  src_e             sel_l, sel_r;

  logic [ATT_W-1:0]         code_a [NCH];
  src_e                     sel_a  [NCH];
  logic signed [DATA_W-1:0] src_a  [NCH];
  logic signed [DATA_W-1:0] res_a  [NCH];
  logic signed [DATA_W-1:0] out_d  [NCH];
  logic signed [DATA_W-1:0] out_q  [NCH];
  logic                     vld_d, vld_q;

  smm_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .code_l  (code_l),
    .code_r  (code_r),
    .sel_l   (sel_l),
    .sel_r   (sel_r)
  );

  assign code_a[0] = code_l;
  assign code_a[1] = code_r;
  assign sel_a[0]  = sel_l;
  assign sel_a[1]  = sel_r;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    smm_src_sel #(.DATA_W(DATA_W)) u_sel (
      .smp_l (in_l),
      .smp_r (in_r),
      .sel   (sel_a[ch]),
      .src   (src_a[ch])
    );
    smm_scale #(.DATA_W(DATA_W)) u_scale (
      .smp  (src_a[ch]),
      .code (code_a[ch]),
      .res  (res_a[ch])
    );
    assign out_d[ch] = in_valid ? res_a[ch] : out_q[ch];
  end

  assign vld_d = in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) out_q[i] <= '0;
      vld_q <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) out_q[i] <= out_d[i];
      vld_q <= vld_d;
    end
  end

  assign out_l     = out_q[0];
  assign out_r     = out_q[1];
  assign out_valid = vld_q;
endmodule

// File: rtl/smm_checker.sv
module smm_checker
  import smm_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic signed [DATA_W-1:0] in_l,
  input logic signed [DATA_W-1:0] out_l,
  input logic signed [DATA_W-1:0] out_r,
  input logic                     out_valid,
  input logic [ATT_W-1:0]         code_l,
  input logic [ATT_W-1:0]         code_r,
  input src_e                     sel_l,
  input src_e                     sel_r
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_l) && $stable(out_r))); // R8

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8

  AST_VALID_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R8

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_l == SRC_MUTE && sel_r == SRC_MUTE) |=> (out_l == '0 && out_r == '0)); // R7

  AST_ZERO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && code_r == '0) |=> out_r == '0); // R5

  AST_LEFT_UNITY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sel_l == SRC_L && code_l == '1) |=> out_l == $past(in_l)); // R2
endmodule

bind stereo_mode_mixer smm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_l      (in_l),
  .out_l     (out_l),
  .out_r     (out_r),
  .out_valid (out_valid),
  .code_l    (code_l),
  .code_r    (code_r),
  .sel_l     (sel_l),
  .sel_r     (sel_r)
);

// File: tb/stereo_mode_mixer_tb.sv
module stereo_mode_mixer_tb_top;
  localparam int DW = 18;
  localparam int MAXP = (1 << (DW-1)) - 1;
  localparam int MINN = -(1 << (DW-1));

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic signed [DW-1:0] in_l, in_r;
  logic wr_en;
  logic [1:0] wr_addr;
  logic [15:0] wr_data;
  logic signed [DW-1:0] out_l, out_r;
  logic out_valid;

  int n_chk = 0;
  int n_err = 0;
  string req = "R1";
  int mregs [4];
  int exp_l = 0, exp_r = 0, exp_v = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  stereo_mode_mixer #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_l(out_l), .out_r(out_r), .out_valid(out_valid));

  function automatic int pick(input int sel, input int l, input int r);
    int s;
    case (sel)
      1: return l;
      2: return r;
      3: begin s = l + r; return s >>> 1; end
      default: return 0;
    endcase
  endfunction

  function automatic int att(input int x, input int c);
    return (x * c) / 255;
  endfunction

  task automatic check(input string what, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic step(input bit v, input int l, input int r,
                      input bit we, input int a, input int d);
    int m3, cl, cr;
    @(negedge clk);
    in_valid = v; in_l = DW'(l); in_r = DW'(r);
    wr_en = we; wr_addr = 2'(a); wr_data = 16'(d);
    if (v) begin
      m3 = mregs[3];
      cl = mregs[0] & 255;
      cr = ((m3 & 8) != 0) ? cl : (mregs[1] & 255);
      exp_l = att(pick((m3 >> 4) & 3, l, r), cl);
      exp_r = att(pick((m3 >> 6) & 3, l, r), cr);
    end
    exp_v = v;
    if (we) mregs[a] = d & 16'hFFFF;
    @(posedge clk); #1;
    check("out_l", int'(out_l), exp_l);
    check("out_r", int'(out_r), exp_r);
    check("out_valid", int'(out_valid), exp_v);
  endtask

  task automatic wr(input int a, input int d);
    step(1'b0, 0, 0, 1'b1, a, d);
  endtask

  task automatic frame(input int l, input int r);
    step(1'b1, l, r, 1'b0, 0, 0);
  endtask

  task automatic rnd_frames(input int n);
    for (int i = 0; i < n; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      frame(int'($signed(seed[DW+7:8])), int'($signed(seed[DW+13:14])));
    end
  endtask

  task automatic extremes();
    frame(MAXP, MAXP);
    frame(MINN, MINN);
    frame(MAXP, MINN);
    frame(-3, 0);
    frame(1, 2);
  endtask

  initial begin
    #(4 * 200000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    mregs[0] = 16'h00FF; mregs[1] = 16'h02FF; mregs[2] = 16'h0400; mregs[3] = 16'h0690;
    rst_n = 1'b0; in_valid = 1'b0; in_l = '0; in_r = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req = "R1";
    check("reset out_l", int'(out_l), 0);
    check("reset out_r", int'(out_r), 0);
    check("reset out_valid", int'(out_valid), 0);
    step(1'b0, 5, 7, 1'b0, 0, 0);
    rnd_frames(6);
    frame(1000, -2000);

    req = "R8";
    step(1'b0, 111, 222, 1'b0, 0, 0);
    step(1'b0, -5, 9, 1'b0, 0, 0);
    frame(42, -42);
    step(1'b0, 77, 88, 1'b0, 0, 0);

    req = "R2";
    wr(3, 16'h0610); rnd_frames(3);
    wr(3, 16'h0620); rnd_frames(3);
    req = "R3";
    wr(3, 16'h0650); rnd_frames(3);
    wr(3, 16'h06A0); rnd_frames(3);
    wr(3, 16'h0660); rnd_frames(3);

    req = "R4";
    wr(3, 16'h06F0); rnd_frames(4); extremes();
    wr(3, 16'h0630); extremes();
    wr(3, 16'h06C0); extremes();

    req = "R5";
    wr(3, 16'h0690);
    wr(0, 16'h0080); wr(1, 16'h0201); rnd_frames(4); extremes();
    wr(0, 16'h0000); wr(1, 16'h02FE); rnd_frames(3); extremes();
    wr(0, 16'h0037); wr(1, 16'h0200); rnd_frames(3);

    req = "R6";
    wr(0, 16'h0040); wr(1, 16'h02C0);
    wr(3, 16'h0698); rnd_frames(3);
    wr(1, 16'h0205); rnd_frames(2);
    wr(3, 16'h06F8); extremes();
    wr(3, 16'h0690); rnd_frames(2);

    req = "R7";
    wr(0, 16'h00FF); wr(1, 16'h02FF);
    wr(3, 16'h0600); rnd_frames(3); extremes();
    wr(3, 16'h0640); rnd_frames(2);
    wr(3, 16'h0601); frame(MINN, MAXP);

    req = "R9";
    wr(3, 16'h0690);
    step(1'b1, 500, 600, 1'b1, 3, 16'h0660);
    frame(500, 600);
    step(1'b1, -800, 300, 1'b1, 0, 16'h0010);
    frame(-800, 300);
    step(1'b1, 1234, -4321, 1'b1, 2, 16'h0000);
    frame(1234, -4321);
    step(1'b0, 0, 0, 1'b0, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule